// File: doc/BRIEF.md
# Smart Card Power-Up and Power-Down Sequencer

This block controls the supply and signal bring-up of a contact smart card. The host asks for the card to be powered by pulling an active-low command line low. When a card is seated, the sequencer raises five enables one at a time, in this order: the charge pump, the card supply regulator, the I/O transceivers, the card clock buffer and the reset release. Each enable after the first waits a programmable number of timebase ticks. A free-running tick pulse from elsewhere in the chip sets the pace.

Power-down runs the same ladder in reverse order. It starts when the host raises the command, or when the block sees over-temperature, undervoltage on the logic supply, or removal of the card. A short on the card supply is acted on only once the full activation ladder has been climbed. When the card is already active, the short is acted on in the very next cycle. A fault-driven power-down pulls an active-low fault flag low, and the flag stays low until the host raises the command. After any power-down, the host must raise the command and lower it again before a new power-up is accepted.

Top module: `sc_power_seq`

## Requirements
- R1: After reset, all five enables are low and the fault flag `fault_n_o` is high.
- R2: A power-up starts from idle only when the card is present, `cmd_n_i` is low, over-temperature and undervoltage are both clear, and the sequencer is armed. The pump enable rises on the first clock edge that sees these conditions.
- R3: `det_pol_i` = 1 means a high level on `card_det_i` signals a present card. `det_pol_i` = 0 means a low level does.
- R4: Enables rise one per step in the order pump, supply, I/O, clock, reset release. Each later step comes on the STEP_TICKS-th tick after the previous step. At most one enable changes per clock.
- R5: Raising `cmd_n_i` during power-up or while active drops the highest raised enable on the next edge. The rest then fall in reverse order, one per STEP_TICKS ticks, and the I/O enable is always low before the supply enable falls. This path leaves the fault flag high.
- R6: Over-temperature, undervoltage or card removal during power-up or while active drops the highest raised enable on the next edge, continues the reverse ladder, and drives `fault_n_o` low.
- R7: A supply short seen during power-up has no effect until all five enables are high.
- R8: A supply short while fully active drops reset release on the next edge and drives `fault_n_o` low. The other four enables then fall in reverse order.
- R9: Once low, `fault_n_o` stays low until the clock edge that follows a rising edge of `cmd_n_i`.
- R10: A new power-up is refused until the ladder has fully unwound and `cmd_n_i` has been seen high while idle and then low.
- R11: With no tick pulses, no step happens during power-up or power-down, apart from the immediate first drop of R5, R6 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse, one cycle wide |
| det_pol_i | input | 1 | Presence polarity: 1 = high means present |
| card_det_i | input | 1 | Raw card-detect switch level |
| cmd_n_i | input | 1 | Host power request, active low |
| ovtemp_i | input | 1 | Over-temperature alarm |
| uvlo_i | input | 1 | Logic-supply undervoltage alarm |
| vshort_i | input | 1 | Card-supply short-circuit alarm |
| pump_en_o | output | 1 | Charge pump enable |
| vcc_en_o | output | 1 | Card supply regulator enable |
| io_en_o | output | 1 | I/O transceiver enable (low = high impedance) |
| clk_en_o | output | 1 | Card clock buffer enable |
| rst_rel_o | output | 1 | Card reset release (high = card out of reset) |
| fault_n_o | output | 1 | Fault flag, active low |

## Verification
The assertions check the per-cycle rules on every clock. They check that the ladder moves at most one rung per clock, that a step only follows a tick, and that a short during power-up never starts a power-down. They also check that a short or any other fault while active forces an immediate drop, and that a fault event always lowers the flag. Other behaviour can only be shown by the bench scenarios, each of which plays a full history. These cover the exact tick counts between rungs, the re-arm rule after the command is toggled during power-down, both presence polarities, and the fault flag holding through a whole power-down until the command rises.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

  localparam int unsigned NUM_STEPS = 5;
  localparam int unsigned LVL_W     = $clog2(NUM_STEPS + 1);

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_UP   = 2'd1,
    PH_ON   = 2'd2,
    PH_DOWN = 2'd3
  } phase_t;

  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_FULL = lvl_t'(NUM_STEPS);
  localparam lvl_t LVL_ONE  = lvl_t'(1);

  // Present when the raw level equals the selected active level.
  function automatic logic card_here(input logic raw, input logic pol);
    return (raw == pol);
  endfunction

  function automatic lvl_t lvl_inc(input lvl_t l);
    return (l == LVL_FULL) ? l : lvl_t'(l + lvl_t'(1));
  endfunction

  function automatic lvl_t lvl_dec(input lvl_t l);
    return (l == '0) ? l : lvl_t'(l - lvl_t'(1));
  endfunction

  // Enable i is on while the ladder stands above rung i.
  function automatic logic rung_on(input lvl_t l, input int unsigned i);
    return (int'(l) > int'(i));
  endfunction

endpackage

// File: rtl/sc_tick_timer.sv
module sc_tick_timer #(
  parameter int unsigned STEP_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic step_due_o
);

  localparam int unsigned CW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign step_due_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  // R11
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/sc_fault_mon.sv
module sc_fault_mon
  import sc_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   card_raw_i,
  input  logic   det_pol_i,
  input  logic   ovtemp_i,
  input  logic   uvlo_i,
  input  logic   vshort_i,
  input  logic   cmd_n_i,
  input  phase_t phase_i,
  output logic   present_o,
  output logic   hard_fault_o,
  output logic   short_now_o,
  output logic   fault_evt_o,
  output logic   fault_n_o
);

  logic cmd_n_q;
  logic flag_q;
  logic cmd_rise;

  assign present_o    = card_here(card_raw_i, det_pol_i);
  assign hard_fault_o = ovtemp_i | uvlo_i | ~present_o;
  // A short only counts once the ladder is complete.
  assign short_now_o  = vshort_i && (phase_i == PH_ON);
  assign fault_evt_o  = ((phase_i == PH_UP) && hard_fault_o) ||
                        ((phase_i == PH_ON) && (hard_fault_o || vshort_i));
  assign cmd_rise     = cmd_n_i && !cmd_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_n_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      cmd_n_q <= cmd_n_i;
      if (fault_evt_o)   flag_q <= 1'b1;
      else if (cmd_rise) flag_q <= 1'b0;
    end
  end

  assign fault_n_o = ~flag_q;

  // R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_evt_o |=> !fault_n_o);

  // R9
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cmd_n_i) && !fault_evt_o) |=> fault_n_o);

endmodule

// File: rtl/sc_seq_fsm.sv
module sc_seq_fsm
  import sc_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cmd_n_i,
  input  logic   present_i,
  input  logic   ovtemp_i,
  input  logic   uvlo_i,
  input  logic   hard_fault_i,
  input  logic   short_now_i,
  input  logic   step_due_i,
  output phase_t phase_o,
  output lvl_t   level_o,
  output logic   start_evt_o,
  output logic   deact_evt_o,
  output logic   step_evt_o,
  output logic   timer_clr_o
);

  phase_t phase_q, phase_d;
  lvl_t   level_q, level_d;
  logic   armed_q, armed_d;

  assign start_evt_o = (phase_q == PH_IDLE) && armed_q && !cmd_n_i &&
                       present_i && !ovtemp_i && !uvlo_i;
  assign deact_evt_o = ((phase_q == PH_UP) && (cmd_n_i || hard_fault_i)) ||
                       ((phase_q == PH_ON) && (cmd_n_i || hard_fault_i || short_now_i));
  assign step_evt_o  = !deact_evt_o && step_due_i &&
                       ((phase_q == PH_UP) || (phase_q == PH_DOWN));
  assign timer_clr_o = start_evt_o || deact_evt_o || step_evt_o || (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    level_d = level_q;
    armed_d = armed_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (cmd_n_i) armed_d = 1'b1;
        if (start_evt_o) begin
          phase_d = PH_UP;
          level_d = LVL_ONE;
          armed_d = 1'b0;
        end
      end
      PH_UP: begin
        if (deact_evt_o) begin
          level_d = lvl_dec(level_q);
          phase_d = (level_q == LVL_ONE) ? PH_IDLE : PH_DOWN;
        end else if (step_evt_o) begin
          level_d = lvl_inc(level_q);
          if (level_d == LVL_FULL) phase_d = PH_ON;
        end
      end
      PH_ON: begin
        if (deact_evt_o) begin
          level_d = lvl_dec(level_q);
          phase_d = PH_DOWN;
        end
      end
      PH_DOWN: begin
        if (step_evt_o) begin
          level_d = lvl_dec(level_q);
          if (level_q == LVL_ONE) phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      level_q <= '0;
      armed_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      level_q <= level_d;
      armed_q <= armed_d;
    end
  end

  assign phase_o = phase_q;
  assign level_o = level_q;

  // R4
  level_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q == $past(level_q)) || (level_q == lvl_t'($past(level_q) + lvl_t'(1))) ||
    (lvl_t'(level_q + lvl_t'(1)) == $past(level_q)));

  // R2
  start_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_IDLE) && (cmd_n_i || !present_i)) |=> (phase_q == PH_IDLE));

  // R10
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_IDLE) && !armed_q) |=> (phase_q == PH_IDLE));

  // R7
  short_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_UP) && !cmd_n_i && !hard_fault_i) |=>
      ((phase_q == PH_UP) || (phase_q == PH_ON)));

  // R8
  short_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_ON) && short_now_i) |=>
      ((phase_q == PH_DOWN) && (level_q == lvl_t'(NUM_STEPS - 1))));

  // R6
  hard_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((phase_q == PH_UP) || (phase_q == PH_ON)) && hard_fault_i) |=>
      (level_q < $past(level_q)));

endmodule

// File: rtl/sc_power_seq.sv
module sc_power_seq
  import sc_seq_pkg::*;
#(
  parameter int unsigned STEP_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic det_pol_i,
  input  logic card_det_i,
  input  logic cmd_n_i,
  input  logic ovtemp_i,
  input  logic uvlo_i,
  input  logic vshort_i,
  output logic pump_en_o,
  output logic vcc_en_o,
  output logic io_en_o,
  output logic clk_en_o,
  output logic rst_rel_o,
  output logic fault_n_o
);

  phase_t phase;
  lvl_t   level;
  logic   present, hard_fault, short_now, fault_evt;
  logic   start_evt, deact_evt, step_evt, timer_clr, step_due;
  logic [NUM_STEPS-1:0] rung_en;

  sc_fault_mon u_fault (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .card_raw_i  (card_det_i),
    .det_pol_i   (det_pol_i),
    .ovtemp_i    (ovtemp_i),
    .uvlo_i      (uvlo_i),
    .vshort_i    (vshort_i),
    .cmd_n_i     (cmd_n_i),
    .phase_i     (phase),
    .present_o   (present),
    .hard_fault_o(hard_fault),
    .short_now_o (short_now),
    .fault_evt_o (fault_evt),
    .fault_n_o   (fault_n_o)
  );

  sc_tick_timer #(.STEP_TICKS(STEP_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (timer_clr),
    .tick_i    (tick_i),
    .step_due_o(step_due)
  );

  sc_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_n_i     (cmd_n_i),
    .present_i   (present),
    .ovtemp_i    (ovtemp_i),
    .uvlo_i      (uvlo_i),
    .hard_fault_i(hard_fault),
    .short_now_i (short_now),
    .step_due_i  (step_due),
    .phase_o     (phase),
    .level_o     (level),
    .start_evt_o (start_evt),
    .deact_evt_o (deact_evt),
    .step_evt_o  (step_evt),
    .timer_clr_o (timer_clr)
  );

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_rung
    assign rung_en[g] = rung_on(level, g);
  end

  assign pump_en_o = rung_en[0];
  assign vcc_en_o  = rung_en[1];
  assign io_en_o   = rung_en[2];
  assign clk_en_o  = rung_en[3];
  assign rst_rel_o = rung_en[4];

  // R11
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(phase) == PH_UP || $past(phase) == PH_DOWN) && !$past(deact_evt) &&
     (level != $past(level))) |-> $past(tick_i));

  // R5
  io_before_vcc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vcc_en_o) |-> (!$past(io_en_o) && !io_en_o));

  // R2
  pump_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pump_en_o) |-> ($past(start_evt) && !vcc_en_o));

endmodule

// File: tb/sc_power_seq_tb.sv
`timescale 1ns/1ps
module sc_power_seq_tb;

  localparam int unsigned S  = 2;
  localparam int          NV = 43;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, det_pol = 1'b1, det = 1'b1, cmd_n = 1'b1;
  logic ot = 1'b0, uv = 1'b0, sh = 1'b0;
  logic pump, vcc, io, cken, rrel, fault_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sc_power_seq #(.STEP_TICKS(S)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .det_pol_i(det_pol),
    .card_det_i(det), .cmd_n_i(cmd_n), .ovtemp_i(ot), .uvlo_i(uv),
    .vshort_i(sh), .pump_en_o(pump), .vcc_en_o(vcc), .io_en_o(io),
    .clk_en_o(cken), .rst_rel_o(rrel), .fault_n_o(fault_n)
  );

  // Fields: req, cycles, {cmd_n,det,ot,uv,sh}, expected {fault_n,rrel,cken,io,vcc,pump}
  localparam logic [18:0] VEC [NV] = '{
    {4'd10, 4'd2, 5'b11000, 6'b100000}, // R10 arm in idle
    {4'd2,  4'd1, 5'b01000, 6'b100001}, // R2 pump first
    {4'd4,  4'd2, 5'b01000, 6'b100011}, // R4
    {4'd4,  4'd2, 5'b01000, 6'b100111}, // R4
    {4'd4,  4'd4, 5'b01000, 6'b111111}, // R4 full
    {4'd4,  4'd5, 5'b01000, 6'b111111}, // R4 hold
    {4'd5,  4'd1, 5'b11000, 6'b101111}, // R5 reset first
    {4'd5,  4'd2, 5'b11000, 6'b100111}, // R5
    {4'd5,  4'd6, 5'b11000, 6'b100000}, // R5 drained
    {4'd10, 4'd3, 5'b11000, 6'b100000}, // R10
    {4'd2,  4'd1, 5'b01000, 6'b100001}, // R2
    {4'd4,  4'd8, 5'b01000, 6'b111111}, // R4
    {4'd8,  4'd1, 5'b01001, 6'b001111}, // R8 short while on
    {4'd8,  4'd8, 5'b01001, 6'b000000}, // R8 drained, flag held
    {4'd9,  4'd1, 5'b11000, 6'b100000}, // R9 flag clears
    {4'd7,  4'd1, 5'b01001, 6'b100001}, // R7 short at start
    {4'd7,  4'd8, 5'b01001, 6'b111111}, // R7 deferred
    {4'd8,  4'd1, 5'b01001, 6'b001111}, // R8 acts at top
    {4'd8,  4'd8, 5'b01001, 6'b000000}, // R8
    {4'd9,  4'd1, 5'b11000, 6'b100000}, // R9
    {4'd2,  4'd1, 5'b01000, 6'b100001}, // R2
    {4'd5,  4'd1, 5'b11000, 6'b100000}, // R5 abort at rung one
    {4'd10, 4'd1, 5'b11000, 6'b100000}, // R10
    {4'd2,  4'd1, 5'b01000, 6'b100001}, // R2
    {4'd4,  4'd8, 5'b01000, 6'b111111}, // R4
    {4'd5,  4'd1, 5'b11000, 6'b101111}, // R5
    {4'd10, 4'd1, 5'b01000, 6'b101111}, // R10 low again mid power-down
    {4'd5,  4'd7, 5'b01000, 6'b100000}, // R5 drains anyway
    {4'd10, 4'd5, 5'b01000, 6'b100000}, // R10 refused
    {4'd10, 4'd1, 5'b11000, 6'b100000}, // R10 re-arm
    {4'd2,  4'd1, 5'b01000, 6'b100001}, // R2
    {4'd4,  4'd8, 5'b01000, 6'b111111}, // R4
    {4'd6,  4'd1, 5'b01100, 6'b001111}, // R6 over-temperature
    {4'd6,  4'd8, 5'b01100, 6'b000000}, // R6
    {4'd9,  4'd1, 5'b11000, 6'b100000}, // R9
    {4'd2,  4'd1, 5'b01000, 6'b100001}, // R2
    {4'd4,  4'd2, 5'b01000, 6'b100011}, // R4
    {4'd6,  4'd1, 5'b00000, 6'b000001}, // R6 removal mid power-up
    {4'd6,  4'd2, 5'b00000, 6'b000000}, // R6
    {4'd9,  4'd1, 5'b11000, 6'b100000}, // R9
    {4'd2,  4'd3, 5'b01010, 6'b100000}, // R2 undervoltage blocks start
    {4'd2,  4'd1, 5'b01000, 6'b100001}, // R2
    {4'd5,  4'd1, 5'b11000, 6'b100000}  // R5
  };

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] got;
    got = {fault_n, rrel, cken, io, vcc, pump};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected done");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 6'b100000);

    for (int i = 0; i < NV; i++) begin
      {cmd_n, det, ot, uv, sh} = VEC[i][10:6];
      step(int'(VEC[i][14:11]));
      check($sformatf("R%0d", VEC[i][18:15]), VEC[i][5:0]);
    end

    // R3 inverted presence polarity: high level means absent
    det_pol = 1'b0; det = 1'b1; cmd_n = 1'b1;
    step(2);
    cmd_n = 1'b0;
    step(3);
    check("R3", 6'b100000);
    det = 1'b0;
    step(1);
    check("R3", 6'b100001);
    cmd_n = 1'b1;
    step(1);
    check("R3", 6'b100000);

    // R11 no ticks, no steps
    det_pol = 1'b1; det = 1'b1; step(2);
    tick = 1'b0; cmd_n = 1'b0;
    step(1);
    check("R11", 6'b100001);
    step(10);
    check("R11", 6'b100001);
    tick = 1'b1; step(1); tick = 1'b0; step(1);
    check("R11", 6'b100001);
    tick = 1'b1; step(1); tick = 1'b0;
    check("R11", 6'b100011);
    step(6);
    check("R11", 6'b100011);
    tick = 1'b1; cmd_n = 1'b1;
    step(10);
    check("R5", 6'b100000);

    // R1 reset while fully active
    step(1); cmd_n = 1'b0;
    step(9);
    check("R4", 6'b111111);
    rst_n = 1'b0;
    step(1);
    check("R1", 6'b100000);
    rst_n = 1'b1;
    step(3);
    check("R10", 6'b100000);

    finish_run();
  end

endmodule